// File: doc/BRIEF.md
# Interrupt vector sequencer

This block runs the entry and exit sequences of interrupt service for an 8-bit processor core with a 16-bit address space. It watches an active-low maskable request pin, an active-low non-maskable request pin and a software-interrupt strobe from the instruction decoder. It chooses one source and saves the processor registers on a descending stack in memory. It then reads the two-byte service address from that source's fixed vector pair and hands the new register values back to the core in a single load strobe.

The core presents its live register values on the input ports and a pulse on `boundary` at each instruction boundary. Hardware requests are taken only on such a pulse. A software interrupt or a return-from-interrupt request from the decoder is taken in the cycle it is raised. The return sequence reads the saved frame back and restores every register, including the mask bit held in the saved condition codes. Memory is reached through a single byte-wide request port that makes one access per cycle. During the two vector reads the block drives the interrupt-acknowledge code on its bus-status output.

Top module: `irq_vec_seq`

## Requirements
- R1: While reset is asserted and afterwards until a request is taken, `busy`, `mem_req`, `mem_we` and `regs_load` are 0 and `bus_state` is 2'b00.
- R2: A high-to-low transition of `nmi_n` is latched as pending and is taken at the next `boundary` pulse, whatever the mask bit. Its service address is read from 0xFFFC (high byte) and 0xFFFD (low byte). Holding `nmi_n` low with no new falling edge starts nothing further.
- R3: A low `irq_n` is taken at a `boundary` pulse only when bit 4 of `cc_in` (the mask bit) is 0, with the service address at 0xFFF8/0xFFF9. When the mask bit is 1, no memory access takes place and `busy` stays 0.
- R4: `swi_req` is taken in the cycle it is high, with no `boundary` needed and whatever the mask bit. Its service address is at 0xFFFA/0xFFFB. In that cycle it wins over any pending hardware request.
- R5: When an NMI is pending and `irq_n` is low at the same `boundary` pulse, the NMI is taken first. The IRQ follows at a later pulse.
- R6: Entry makes seven consecutive write cycles. The first address is `sp_in` and each later address is one lower. The bytes written, in order, are PC low, PC high, X low, X high, A, B and the unmodified condition codes.
- R7: After stacking, the block reads the lower vector address and then the next one in two consecutive cycles. It expects `mem_rdata` to carry the byte at the previous cycle's read address. `bus_state` is 2'b01 in exactly those two cycles and 2'b00 in all other cycles.
- R8: An entry keeps `busy` high for 10 cycles, and `regs_load` pulses for one cycle in the following cycle. With that pulse, `pc_out` is {high byte, low byte} of the vector, `sp_out` is `sp_in`-7, `cc_out` is `cc_in` with bit 4 set, and `a_out`, `b_out` and `x_out` equal the inputs.
- R9: `rti_req` starts a return that reads addresses `sp_in`+1 through `sp_in`+7 in ascending order. Those bytes restore CC, B, A, X high, X low, PC high and PC low in that order. `cc_out` comes from memory, including its bit 4, and `sp_out` is `sp_in`+7. `busy` stays high for 8 cycles, and `regs_load` pulses in the next cycle.
- R10: While `busy` is high, `swi_req`, `rti_req` and `boundary` have no effect. An NMI falling edge seen during that time stays pending and is taken at the first `boundary` pulse after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| swi_req | input | 1 | Software-interrupt strobe from the decoder |
| rti_req | input | 1 | Return-from-interrupt strobe from the decoder |
| boundary | input | 1 | Instruction-boundary pulse |
| pc_in | input | 16 | Current program counter |
| x_in | input | 16 | Current index register |
| a_in | input | 8 | Current accumulator A |
| b_in | input | 8 | Current accumulator B |
| cc_in | input | 8 | Current condition codes, bit 4 is the mask |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after the read request |
| busy | output | 1 | Sequence in progress |
| bus_state | output | 2 | Bus-status code, 01 during the vector reads |
| regs_load | output | 1 | One-cycle strobe: outputs below are the new registers |
| pc_out | output | 16 | New program counter |
| x_out | output | 16 | New index register |
| a_out | output | 8 | New accumulator A |
| b_out | output | 8 | New accumulator B |
| cc_out | output | 8 | New condition codes |
| sp_out | output | 16 | New stack pointer |

## Verification
A request is taken at the clock edge that samples it. `busy` rises in the next cycle and stays high for 10 cycles on entry and for 8 on return, and `regs_load` follows one cycle after `busy` falls. Read data for a request arrives one cycle later through the bench's memory model. The monitor samples on the falling edge, counts `busy` and acknowledge cycles between load strobes, and compares those counts with the latency stored in each expected item. It also compares every output field when the strobe appears. For the masked, held-low and busy cases, the bench watches `busy` and `mem_req` at the falling edge of each cycle, and it counts any load strobe that no item predicts as a failure.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

   typedef enum logic [1:0] {
      BS_NORMAL   = 2'b00,
      BS_INT_ACK  = 2'b01,
      BS_SYNC_ACK = 2'b10,
      BS_HALT_ACK = 2'b11
   } bus_state_e;

   typedef enum logic [1:0] {
      SRC_IRQ,
      SRC_SWI,
      SRC_NMI,
      SRC_RTI
   } src_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_VHI,
      ST_VLO,
      ST_VEND,
      ST_POP,
      ST_PEND
   } seq_st_e;

   // frame slots, indexed in stacking order
   localparam int FRAME_BYTES = 7;
   localparam int IDX_PCL = 0;
   localparam int IDX_PCH = 1;
   localparam int IDX_XL  = 2;
   localparam int IDX_XH  = 3;
   localparam int IDX_A   = 4;
   localparam int IDX_B   = 5;
   localparam int IDX_CC  = 6;

endpackage

// File: rtl/ivs_nmi_edge.sv
module ivs_nmi_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_n,
   output logic fall
);

   logic lvl;
   logic prev;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must be zero or positive");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign lvl = nmi_n;
   end else begin : g_sync
      logic [SYNC_STAGES:0] chain;
      assign chain[0] = nmi_n;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[SYNC_STAGES:1] <= '1;
         else        chain[SYNC_STAGES:1] <= chain[SYNC_STAGES-1:0];
      end
      assign lvl = chain[SYNC_STAGES];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= lvl;
   end

   assign fall = prev & ~lvl;

endmodule

// File: rtl/ivs_arbiter.sv
module ivs_arbiter
   import ivs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic boundary,
   input  logic irq_n,
   input  logic swi_req,
   input  logic rti_req,
   input  logic nmi_fall,
   input  logic i_mask,
   output logic start,
   output src_e src
);

   logic nmi_pend;
   logic take_swi, take_rti, take_nmi, take_irq, hw_slot;

   assign take_swi = idle & swi_req;
   assign take_rti = idle & ~swi_req & rti_req;
   assign hw_slot  = idle & boundary & ~swi_req & ~rti_req;
   assign take_nmi = hw_slot & nmi_pend;
   assign take_irq = hw_slot & ~nmi_pend & ~irq_n & ~i_mask;

   assign start = take_swi | take_rti | take_nmi | take_irq;

   always_comb begin
      if (take_swi)      src = SRC_SWI;
      else if (take_rti) src = SRC_RTI;
      else if (take_nmi) src = SRC_NMI;
      else               src = SRC_IRQ;
   end

   // a new edge wins over the clear of an older one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_pend <= 1'b0;
      else        nmi_pend <= nmi_fall | (nmi_pend & ~take_nmi);
   end

   // R2
   nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_fall |=> nmi_pend);

endmodule

// File: rtl/ivs_engine.sv
module ivs_engine
   import ivs_pkg::*;
#(
   parameter int DW    = 8,
   parameter int AW    = 16,
   parameter int I_BIT = 4,
   parameter logic [AW-1:0] VEC_IRQ = 'hFFF8,
   parameter logic [AW-1:0] VEC_SWI = 'hFFFA,
   parameter logic [AW-1:0] VEC_NMI = 'hFFFC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  src_e          src,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] x_in,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   input  logic [DW-1:0] cc_in,
   input  logic [AW-1:0] sp_in,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          idle,
   output logic [1:0]    bus_state,
   output logic          regs_load,
   output logic [AW-1:0] pc_out,
   output logic [AW-1:0] x_out,
   output logic [DW-1:0] a_out,
   output logic [DW-1:0] b_out,
   output logic [DW-1:0] cc_out,
   output logic [AW-1:0] sp_out
);

   localparam int FRAME = FRAME_BYTES;
   localparam int CW    = $clog2(FRAME);
   localparam logic [CW-1:0] LAST  = CW'(FRAME - 1);
   localparam logic [DW-1:0] MASKB = DW'(1) << I_BIT;

   seq_st_e       st;
   logic [CW-1:0] cnt;
   logic [AW-1:0] ptr;
   logic [AW-1:0] vec;
   logic [AW-1:0] vec_sel;
   logic [DW-1:0] vhi;
   logic [DW-1:0] frm [FRAME];

   always_comb begin
      case (src)
         SRC_NMI: vec_sel = VEC_NMI;
         SRC_SWI: vec_sel = VEC_SWI;
         default: vec_sel = VEC_IRQ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         ptr       <= '0;
         vec       <= '0;
         vhi       <= '0;
         regs_load <= 1'b0;
         pc_out    <= '0;
         x_out     <= '0;
         a_out     <= '0;
         b_out     <= '0;
         cc_out    <= '0;
         sp_out    <= '0;
         for (int i = 0; i < FRAME; i++) frm[i] <= '0;
      end else begin
         regs_load <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  cnt          <= '0;
                  frm[IDX_PCL] <= pc_in[DW-1:0];
                  frm[IDX_PCH] <= pc_in[AW-1:DW];
                  frm[IDX_XL]  <= x_in[DW-1:0];
                  frm[IDX_XH]  <= x_in[AW-1:DW];
                  frm[IDX_A]   <= a_in;
                  frm[IDX_B]   <= b_in;
                  frm[IDX_CC]  <= cc_in;
                  if (src == SRC_RTI) begin
                     st  <= ST_POP;
                     ptr <= sp_in + AW'(1);
                  end else begin
                     st  <= ST_PUSH;
                     ptr <= sp_in;
                     vec <= vec_sel;
                  end
               end
            end
            ST_PUSH: begin
               ptr <= ptr - AW'(1);
               cnt <= cnt + CW'(1);
               if (cnt == LAST) st <= ST_VHI;
            end
            ST_VHI: st <= ST_VLO;
            ST_VLO: begin
               vhi <= mem_rdata;
               st  <= ST_VEND;
            end
            ST_VEND: begin
               pc_out    <= {vhi, mem_rdata};
               x_out     <= {frm[IDX_XH], frm[IDX_XL]};
               a_out     <= frm[IDX_A];
               b_out     <= frm[IDX_B];
               cc_out    <= frm[IDX_CC] | MASKB;
               sp_out    <= ptr;
               regs_load <= 1'b1;
               st        <= ST_IDLE;
            end
            ST_POP: begin
               // byte requested in the previous cycle lands now
               if (cnt != '0) frm[CW'(FRAME) - cnt] <= mem_rdata;
               cnt <= cnt + CW'(1);
               if (cnt == LAST) st  <= ST_PEND;
               else             ptr <= ptr + AW'(1);
            end
            ST_PEND: begin
               pc_out    <= {frm[IDX_PCH], mem_rdata};
               x_out     <= {frm[IDX_XH], frm[IDX_XL]};
               a_out     <= frm[IDX_A];
               b_out     <= frm[IDX_B];
               cc_out    <= frm[IDX_CC];
               sp_out    <= ptr;
               regs_load <= 1'b1;
               st        <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      bus_state = BS_NORMAL;
      case (st)
         ST_PUSH: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ptr;
            mem_wdata = frm[cnt];
         end
         ST_VHI: begin
            mem_req   = 1'b1;
            mem_addr  = vec;
            bus_state = BS_INT_ACK;
         end
         ST_VLO: begin
            mem_req   = 1'b1;
            mem_addr  = vec + AW'(1);
            bus_state = BS_INT_ACK;
         end
         ST_POP: begin
            mem_req  = 1'b1;
            mem_addr = ptr;
         end
         default: ;
      endcase
   end

   assign idle = (st == ST_IDLE);
   assign busy = ~idle;

   // R3
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && src == SRC_IRQ) |-> !cc_in[I_BIT]);

   // R10
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> st == ST_IDLE);

   // R6
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) - AW'(1));

   // R9
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POP && $past(st == ST_POP)) |-> mem_addr == $past(mem_addr) + AW'(1));

   // R7
   ack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_state == BS_INT_ACK) |-> (mem_req && !mem_we));

   // R8
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      regs_load |=> !regs_load);

endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq
   import ivs_pkg::*;
#(
   parameter int DW       = 8,
   parameter int AW       = 16,
   parameter int I_BIT    = 4,
   parameter int NMI_SYNC = 0,
   parameter logic [AW-1:0] VEC_IRQ = 'hFFF8,
   parameter logic [AW-1:0] VEC_SWI = 'hFFFA,
   parameter logic [AW-1:0] VEC_NMI = 'hFFFC
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          irq_n,
   input  logic          nmi_n,
   input  logic          swi_req,
   input  logic          rti_req,
   input  logic          boundary,
   input  logic [AW-1:0] pc_in,
   input  logic [AW-1:0] x_in,
   input  logic [DW-1:0] a_in,
   input  logic [DW-1:0] b_in,
   input  logic [DW-1:0] cc_in,
   input  logic [AW-1:0] sp_in,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic [1:0]    bus_state,
   output logic          regs_load,
   output logic [AW-1:0] pc_out,
   output logic [AW-1:0] x_out,
   output logic [DW-1:0] a_out,
   output logic [DW-1:0] b_out,
   output logic [DW-1:0] cc_out,
   output logic [AW-1:0] sp_out
);

   if (AW != 2 * DW) begin : g_bad_width
      $error("address width must be twice the data width");
   end
   if (I_BIT < 0 || I_BIT >= DW) begin : g_bad_ibit
      $error("mask bit position outside the condition-code byte");
   end

   logic nmi_fall;
   logic idle;
   logic start;
   src_e src;

   ivs_nmi_edge #(.SYNC_STAGES(NMI_SYNC)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .nmi_n (nmi_n),
      .fall  (nmi_fall)
   );

   ivs_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .idle     (idle),
      .boundary (boundary),
      .irq_n    (irq_n),
      .swi_req  (swi_req),
      .rti_req  (rti_req),
      .nmi_fall (nmi_fall),
      .i_mask   (cc_in[I_BIT]),
      .start    (start),
      .src      (src)
   );

   ivs_engine #(
      .DW(DW), .AW(AW), .I_BIT(I_BIT),
      .VEC_IRQ(VEC_IRQ), .VEC_SWI(VEC_SWI), .VEC_NMI(VEC_NMI)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .src       (src),
      .pc_in     (pc_in),
      .x_in      (x_in),
      .a_in      (a_in),
      .b_in      (b_in),
      .cc_in     (cc_in),
      .sp_in     (sp_in),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .busy      (busy),
      .idle      (idle),
      .bus_state (bus_state),
      .regs_load (regs_load),
      .pc_out    (pc_out),
      .x_out     (x_out),
      .a_out     (a_out),
      .b_out     (b_out),
      .cc_out    (cc_out),
      .sp_out    (sp_out)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && bus_state == 2'b00));

endmodule

// File: tb/irq_vec_seq_tb_top.sv
`timescale 1ns/1ps
module irq_vec_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_n = 1'b1, nmi_n = 1'b1, swi_req = 1'b0, rti_req = 1'b0, boundary = 1'b0;
   logic [15:0] pc_in = '0, x_in = '0, sp_in = '0;
   logic [7:0]  a_in = '0, b_in = '0, cc_in = '0;
   logic        mem_req, mem_we, busy, regs_load;
   logic [15:0] mem_addr, pc_out, x_out, sp_out;
   logic [7:0]  mem_wdata, a_out, b_out, cc_out;
   logic [7:0]  mem_rdata = '0;
   logic [1:0]  bus_state;

   int total = 0;
   int bad   = 0;

   typedef struct {
      logic [15:0] pc, sp, x;
      logic [7:0]  a, b, cc;
      int          bcyc, acyc;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   logic [7:0] mem [logic [15:0]];

   always #10 clk = ~clk;

   irq_vec_seq dut_i (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
      .swi_req(swi_req), .rti_req(rti_req), .boundary(boundary),
      .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .b_in(b_in),
      .cc_in(cc_in), .sp_in(sp_in),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .bus_state(bus_state), .regs_load(regs_load),
      .pc_out(pc_out), .x_out(x_out), .a_out(a_out), .b_out(b_out),
      .cc_out(cc_out), .sp_out(sp_out)
   );

   function automatic logic [7:0] rd(input logic [15:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   // memory model: one-cycle read latency
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr] = mem_wdata;
         else        mem_rdata <= rd(mem_addr);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // ---------------- monitor ----------------
   initial begin
      int bcnt = 0;
      int acnt = 0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (busy) bcnt++;
            if (bus_state == 2'b01) begin
               acnt++;
               chk(mem_req && !mem_we && mem_addr >= 16'hFFF8, "R7 ack on vector read", {16'h0, mem_addr}, 32'hFFF8);
            end
            if (mem_we && bus_state != 2'b00)
               chk(1'b0, "R7 ack during write", {30'h0, bus_state}, 0);
            if (regs_load) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R10 unexpected load", {16'h0, pc_out}, 0);
               end else begin
                  exp_t  e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk(pc_out == e.pc, {t, " pc"}, {16'h0, pc_out}, {16'h0, e.pc});
                  chk(sp_out == e.sp, {t, " sp"}, {16'h0, sp_out}, {16'h0, e.sp});
                  chk(cc_out == e.cc, {t, " cc"}, {24'h0, cc_out}, {24'h0, e.cc});
                  chk(x_out == e.x && a_out == e.a && b_out == e.b, {t, " x/a/b"},
                      {x_out, a_out, b_out}, {e.x, e.a, e.b});
                  chk(bcnt == e.bcyc, {t, " busy cycles R8"}, bcnt, e.bcyc);
                  chk(acnt == e.acyc, {t, " ack cycles R7"}, acnt, e.acyc);
               end
               bcnt = 0;
               acnt = 0;
            end
         end
      end
   end

   // ---------------- driver ----------------
   task automatic set_regs(input logic [15:0] pc, x, input logic [7:0] a, b, cc, input logic [15:0] sp);
      pc_in = pc; x_in = x; a_in = a; b_in = b; cc_in = cc; sp_in = sp;
   endtask

   task automatic expect_entry(input logic [15:0] vpc, input string tag);
      exp_t e;
      e.pc = vpc; e.sp = sp_in - 16'd7; e.cc = cc_in | 8'h10;
      e.x = x_in; e.a = a_in; e.b = b_in; e.bcyc = 10; e.acyc = 2;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic expect_ret(input logic [15:0] pc, x, input logic [7:0] a, b, cc, input logic [15:0] sp, input string tag);
      exp_t e;
      e.pc = pc; e.x = x; e.a = a; e.b = b; e.cc = cc; e.sp = sp; e.bcyc = 8; e.acyc = 0;
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic pulse_boundary();
      @(negedge clk) boundary = 1'b1;
      @(negedge clk) boundary = 1'b0;
   endtask

   task automatic wait_load();
      do @(negedge clk); while (!regs_load);
      @(negedge clk);
   endtask

   task automatic quiet_cycles(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) boundary = 1'b1;
         @(negedge clk) boundary = 1'b0;
         chk(!busy && !mem_req, tag, {30'h0, busy, mem_req}, 0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      mem[16'hFFF8] = 8'h12; mem[16'hFFF9] = 8'h34;
      mem[16'hFFFA] = 8'h56; mem[16'hFFFB] = 8'h78;
      mem[16'hFFFC] = 8'h9A; mem[16'hFFFD] = 8'hBC;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req && !mem_we && !regs_load && bus_state == 2'b00, "R1 in reset",
          {27'h0, busy, mem_req, mem_we, regs_load, bus_state}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !mem_req && bus_state == 2'b00, "R1 after reset", {29'h0, busy, mem_req, 1'b0}, 0);

      // R3 unmasked IRQ entry, with R6 stack image
      set_regs(16'h4321, 16'hA55A, 8'h11, 8'h22, 8'hC1, 16'h01FF);
      irq_n = 1'b0;
      expect_entry(16'h1234, "R3 irq entry");
      pulse_boundary();
      irq_n = 1'b1;
      wait_load();
      chk(rd(16'h01FF) == 8'h21 && rd(16'h01FE) == 8'h43, "R6 pc bytes",
          {rd(16'h01FF), rd(16'h01FE)}, 16'h2143);
      chk(rd(16'h01FD) == 8'h5A && rd(16'h01FC) == 8'hA5, "R6 x bytes",
          {rd(16'h01FD), rd(16'h01FC)}, 16'h5AA5);
      chk(rd(16'h01FB) == 8'h11 && rd(16'h01FA) == 8'h22 && rd(16'h01F9) == 8'hC1, "R6 a/b/cc bytes",
          {rd(16'h01FB), rd(16'h01FA), rd(16'h01F9)}, 24'h1122C1);

      // R9 return restores the saved frame
      set_regs(16'h0000, 16'h0000, 8'h00, 8'h00, 8'hFF, 16'h01F8);
      expect_ret(16'h4321, 16'hA55A, 8'h11, 8'h22, 8'hC1, 16'h01FF, "R9 round trip");
      @(negedge clk) rti_req = 1'b1;
      @(negedge clk) rti_req = 1'b0;
      wait_load();

      // R9 return with the saved mask bit set
      mem[16'h0301] = 8'hD5; mem[16'h0302] = 8'h66; mem[16'h0303] = 8'h77;
      mem[16'h0304] = 8'h12; mem[16'h0305] = 8'h34; mem[16'h0306] = 8'hBE; mem[16'h0307] = 8'hEF;
      set_regs(16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0300);
      expect_ret(16'hBEEF, 16'h1234, 8'h77, 8'h66, 8'hD5, 16'h0307, "R9 frame");
      @(negedge clk) rti_req = 1'b1;
      @(negedge clk) rti_req = 1'b0;
      wait_load();

      // R3 masked IRQ is held off
      set_regs(16'h1000, 16'h2000, 8'h33, 8'h44, 8'h10, 16'h0280);
      irq_n = 1'b0;
      quiet_cycles(4, "R3 masked irq");
      irq_n = 1'b1;

      // R2 NMI ignores the mask; held-low level does not retrigger
      @(negedge clk) nmi_n = 1'b0;
      repeat (2) @(negedge clk);
      expect_entry(16'h9ABC, "R2 nmi entry");
      pulse_boundary();
      wait_load();
      quiet_cycles(3, "R2 nmi held low");
      nmi_n = 1'b1;

      // R4 SWI beats pending NMI and IRQ; R5 NMI before IRQ
      set_regs(16'h5000, 16'h6000, 8'h55, 8'h66, 8'h00, 16'h0400);
      @(negedge clk) nmi_n = 1'b0;
      irq_n = 1'b0;
      repeat (2) @(negedge clk);
      expect_entry(16'h5678, "R4 swi first");
      @(negedge clk) begin swi_req = 1'b1; boundary = 1'b1; end
      @(negedge clk) begin swi_req = 1'b0; boundary = 1'b0; end
      wait_load();
      expect_entry(16'h9ABC, "R5 nmi before irq");
      pulse_boundary();
      wait_load();
      expect_entry(16'h1234, "R5 irq after nmi");
      pulse_boundary();
      irq_n = 1'b1;
      wait_load();
      nmi_n = 1'b1;

      // R4 SWI with mask set and no boundary; R10 requests during busy
      set_regs(16'h7000, 16'h8000, 8'h77, 8'h88, 8'h10, 16'h0500);
      expect_entry(16'h5678, "R4 swi masked");
      @(negedge clk) swi_req = 1'b1;
      @(negedge clk) swi_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy, "R10 busy mid-sequence", {31'h0, busy}, 1);
      swi_req = 1'b1; boundary = 1'b1; rti_req = 1'b1; nmi_n = 1'b0;
      @(negedge clk) begin swi_req = 1'b0; boundary = 1'b0; rti_req = 1'b0; end
      wait_load();
      repeat (3) @(negedge clk);
      chk(!busy, "R10 no extra sequence", {31'h0, busy}, 0);
      expect_entry(16'h9ABC, "R10 nmi kept pending");
      pulse_boundary();
      wait_load();
      nmi_n = 1'b1;

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R8 all loads seen", exp_q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule